// File: doc/BRIEF.md
# Coarse-Fine Zoom Output Combiner

This block forms the final output word of a two-step converter. A binary-search coarse conversion produces an 8-bit code. A first-order incremental delta-sigma fine conversion then resolves the residue. It delivers one small signed level per cycle over an oversampling window of 16 cycles. The combiner collects the coarse code, adds up the fine levels in an accumulator that is cleared at every sample, and then forms `coarse * 2^WEIGHT_SH + fine_sum` with a shift and an add. With the default shift of 5, one coarse step equals 32 fine steps. The full fine swing of ±112 therefore covers 3.5 coarse steps, and the fine part may carry the result across a coarse boundary.

A sequencer with three states controls the flow. `ST_IDLE` waits for a start strobe. `ST_COARSE` waits for the coarse strobe. `ST_FINE` counts fine results. The transitions are:
- IDLE→COARSE on start.
- COARSE→FINE on the coarse strobe.
- COARSE→COARSE on a repeated start, which is an error.
- FINE→IDLE on the 16th fine result.
- FINE→COARSE on the 16th fine result together with a start, which is a clean back-to-back sample.
- FINE→COARSE on a start before the 16th result, which is an error.

Top module: `zoom_combiner`

## Requirements
- R1: After reset `zoom_vld` and `zoom_err` are low and `zoom_word` is zero.
- R2: `zoom_word` (15-bit two's complement) equals `crs_code` (8-bit unsigned) times 32 plus the sum of the fine levels of the sample; `fin_lvl` is 4-bit two's complement in the range -7..+7.
- R3: Exactly 16 fine results are summed per sample, and the sum covers ±112 without overflow.
- R4: `zoom_vld` is high for exactly one cycle, the cycle after the clock edge that accepts the 16th fine result.
- R5: The fine sum is cleared at every start strobe, so nothing from an earlier or aborted sample reaches a later result.
- R6: A start strobe that arrives before the 16th fine result of the current sample raises `zoom_err` for one cycle after that edge, produces no `zoom_vld` for the aborted sample, and begins a new sample.
- R7: `fin_vld` outside the fine phase and `crs_code`/`crs_vld` outside the coarse-wait phase have no effect on the result.
- R8: A start strobe in the same cycle as the 16th fine result completes that sample without error and begins the next one.
- R9: Cycles with `fin_vld` low inside the fine phase are not counted and do not change the sum.
- R10: The fine part may push the result past a coarse boundary, down to -112 for code 0 and up to 8272 for code 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| smp_start | input | 1 | Start-of-sample strobe |
| crs_vld | input | 1 | Coarse code strobe |
| crs_code | input | 8 | Coarse code, unsigned |
| fin_vld | input | 1 | Fine result strobe |
| fin_lvl | input | 4 | Fine level, two's complement, -7..+7 |
| zoom_vld | output | 1 | Final word valid, one-cycle pulse |
| zoom_word | output | 15 | Final word, two's complement |
| zoom_err | output | 1 | Aborted-sample flag, one-cycle pulse |

## Verification
Every result is registered once. `zoom_vld`, `zoom_word` and `zoom_err` change at the edge that accepts the 16th fine result or the early start, and hold for the following cycle only. The bench drives inputs on falling edges. It checks the outputs at the very next falling edge after the driving stimulus, and one falling edge later it confirms that the pulse has dropped. Table vectors alternate between dense and gapped fine streams. Directed runs cover the abort, the back-to-back start, ignored strobes and both extremes of the range.

// File: rtl/zoom_combiner_pkg.sv
package zoom_combiner_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2
    } zc_state_e;

    // bits needed for a signed value of magnitude up to m
    function automatic int signed_bits(input int m);
        return $clog2(m + 1) + 1;
    endfunction

endpackage

// File: rtl/zc_fine_acc.sv
module zc_fine_acc
    import zoom_combiner_pkg::*;
#(
    parameter int OSR     = 16,
    parameter int LVL_W   = 4,
    parameter int LVL_MAX = 7,
    parameter int ACC_W   = 8,
    parameter int CNT_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    take,
    input  logic signed [LVL_W-1:0] lvl,
    output logic signed [ACC_W-1:0] acc_next,
    output logic                    last
);

    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [ACC_W-1:0] lvl_ext;

    assign lvl_ext  = ACC_W'(lvl);
    assign acc_next = acc_q + lvl_ext;
    assign last     = take && (cnt_q == CNT_W'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            acc_q <= acc_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the running sum stays within what the accepted count allows
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_q) <= LVL_MAX * int'(cnt_q)) &&
        (int'(acc_q) >= -LVL_MAX * int'(cnt_q)));

    // R5: a start leaves no history behind
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0) && (cnt_q == '0));

    // R3: accepted level is inside the legal range
    p_lvl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (int'(lvl) <= LVL_MAX) && (int'(lvl) >= -LVL_MAX));

endmodule

// File: rtl/zc_scale.sv
module zc_scale #(
    parameter int CODE_W    = 8,
    parameter int WEIGHT_SH = 5,
    parameter int ACC_W     = 8,
    parameter int OUT_W     = 15
) (
    input  logic [CODE_W-1:0]       coarse,
    input  logic signed [ACC_W-1:0] fine,
    output logic signed [OUT_W-1:0] word
);

    logic signed [OUT_W-1:0] coarse_w;
    logic signed [OUT_W-1:0] fine_w;

    always_comb begin
        coarse_w = $signed(OUT_W'(coarse) << WEIGHT_SH);
        fine_w   = OUT_W'(fine);
        word     = coarse_w + fine_w;
    end

endmodule

// File: rtl/zc_seq.sv
module zc_seq
    import zoom_combiner_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      crs_vld,
    input  logic      fin_vld,
    input  logic      fin_last,
    output logic      clr_fine,
    output logic      take_coarse,
    output logic      take_fine,
    output logic      emit,
    output logic      abort
);

    zc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        clr_fine    = start;
        take_coarse = 1'b0;
        take_fine   = 1'b0;
        emit        = 1'b0;
        abort       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_COARSE;
            end
            ST_COARSE: begin
                if (start) begin
                    abort   = 1'b1;
                    state_d = ST_COARSE;
                end else if (crs_vld) begin
                    take_coarse = 1'b1;
                    state_d     = ST_FINE;
                end
            end
            ST_FINE: begin
                take_fine = fin_vld;
                if (fin_last) begin
                    emit    = 1'b1;
                    state_d = start ? ST_COARSE : ST_IDLE;
                end else if (start) begin
                    abort   = 1'b1;
                    state_d = ST_COARSE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R8: completion and abort never coincide
    p_emit_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({emit, abort}));

    // R7: coarse is taken only once per sample, fine only after it
    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_coarse |=> !take_coarse);

endmodule

// File: rtl/zoom_combiner.sv
module zoom_combiner
    import zoom_combiner_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int OSR       = 16,
    parameter int LVL_W     = 4,
    parameter int LVL_MAX   = 7,
    parameter int WEIGHT_SH = 5,
    parameter int OUT_W     = CODE_W + WEIGHT_SH + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_start,
    input  logic              crs_vld,
    input  logic [CODE_W-1:0] crs_code,
    input  logic              fin_vld,
    input  logic [LVL_W-1:0]  fin_lvl,
    output logic              zoom_vld,
    output logic [OUT_W-1:0]  zoom_word,
    output logic              zoom_err
);

    localparam int FINE_MAX = OSR * LVL_MAX;
    localparam int ACC_W    = signed_bits(FINE_MAX);
    localparam int CNT_W    = $clog2(OSR + 1);
    localparam int TOP_MAX  = (((1 << CODE_W) - 1) << WEIGHT_SH) + FINE_MAX;

    logic                    clr_fine, take_coarse, take_fine, emit, abort, fin_last;
    logic [CODE_W-1:0]       coarse_q;
    logic signed [ACC_W-1:0] fine_total;
    logic signed [OUT_W-1:0] word_d;

    zc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (smp_start),
        .crs_vld    (crs_vld),
        .fin_vld    (fin_vld),
        .fin_last   (fin_last),
        .clr_fine   (clr_fine),
        .take_coarse(take_coarse),
        .take_fine  (take_fine),
        .emit       (emit),
        .abort      (abort)
    );

    zc_fine_acc #(
        .OSR    (OSR),
        .LVL_W  (LVL_W),
        .LVL_MAX(LVL_MAX),
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_fine),
        .take    (take_fine),
        .lvl     ($signed(fin_lvl)),
        .acc_next(fine_total),
        .last    (fin_last)
    );

    zc_scale #(
        .CODE_W   (CODE_W),
        .WEIGHT_SH(WEIGHT_SH),
        .ACC_W    (ACC_W),
        .OUT_W    (OUT_W)
    ) u_scale (
        .coarse(coarse_q),
        .fine  (fine_total),
        .word  (word_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           coarse_q <= '0;
        else if (take_coarse) coarse_q <= crs_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zoom_vld  <= 1'b0;
            zoom_err  <= 1'b0;
            zoom_word <= '0;
        end else begin
            zoom_vld <= emit;
            zoom_err <= abort;
            if (emit) zoom_word <= word_d;
        end
    end

    // R4: valid is a single-cycle pulse
    p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zoom_vld |=> !zoom_vld);

    // R6: an aborted sample never reports a word
    p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(zoom_vld && zoom_err));

    // R10: result stays inside the scaled range
    p_word_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zoom_vld |-> (int'($signed(zoom_word)) >= -FINE_MAX) &&
                     (int'($signed(zoom_word)) <= TOP_MAX));

endmodule

// File: tb/tb_zoom_combiner.sv
module tb_zoom_combiner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_start = 1'b0;
    logic        crs_vld = 1'b0;
    logic [7:0]  crs_code = '0;
    logic        fin_vld = 1'b0;
    logic [3:0]  fin_lvl = '0;
    logic        zoom_vld;
    logic [14:0] zoom_word;
    logic        zoom_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    zoom_combiner dut (
        .clk(clk), .rst_n(rst_n), .smp_start(smp_start),
        .crs_vld(crs_vld), .crs_code(crs_code),
        .fin_vld(fin_vld), .fin_lvl(fin_lvl),
        .zoom_vld(zoom_vld), .zoom_word(zoom_word), .zoom_err(zoom_err)
    );

    // coarse[15:8], even-step level[7:4], odd-step level[3:0]
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        {8'd0,   4'sd0,  4'sd0},
        {8'd1,   4'sd1, -4'sd1},
        {8'd100, 4'sd7,  4'sd7},
        {8'd255, 4'sd7,  4'sd7},
        {8'd0,  -4'sd7, -4'sd7},
        {8'd128,-4'sd3,  4'sd2},
        {8'd37,  4'sd5, -4'sd7},
        {8'd200,-4'sd7,  4'sd6}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        smp_start = 0; crs_vld = 0; fin_vld = 0;
        @(negedge clk);
    endtask

    task automatic t_start();
        smp_start = 1; crs_vld = 0; fin_vld = 0;
        @(negedge clk);
        smp_start = 0;
    endtask

    task automatic t_coarse(input logic [7:0] c);
        crs_vld = 1; crs_code = c;
        @(negedge clk);
        crs_vld = 0; crs_code = 8'hA5;
    endtask

    task automatic t_fine(input int l, input bit with_start);
        fin_vld = 1; fin_lvl = 4'(l); smp_start = with_start;
        @(negedge clk);
        fin_vld = 0; smp_start = 0;
    endtask

    function automatic int word_i();
        return int'($signed(zoom_word));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 vld", int'(zoom_vld), 0);
        check("R1 err", int'(zoom_err), 0);
        check("R1 word", word_i(), 0);
        rst_n = 1;
        @(negedge clk);

        // table: R2/R3 dense, R9 gapped on odd vectors
        for (int v = 0; v < NV; v++) begin
            int c, a, b, exp;
            c = int'(VEC[v][15:8]);
            a = int'($signed(VEC[v][7:4]));
            b = int'($signed(VEC[v][3:0]));
            exp = c * 32 + 8 * (a + b);
            t_start();
            t_coarse(8'(c));
            for (int k = 0; k < 16; k++) begin
                t_fine((k % 2 == 0) ? a : b, 1'b0);
                if (k == 14) check("R4 no early vld", int'(zoom_vld), 0);
                if ((v % 2 == 1) && k < 15) idle();
            end
            check("R4 vld", int'(zoom_vld), 1);
            check((v % 2 == 1) ? "R9 word" : "R2 word", word_i(), exp);
            check("R3 err", int'(zoom_err), 0);
            idle();
            check("R4 pulse drop", int'(zoom_vld), 0);
        end

        // R10 extremes crossing coarse boundaries
        t_start(); t_coarse(8'd255);
        for (int k = 0; k < 16; k++) t_fine(7, 1'b0);
        check("R10 top", word_i(), 8272);
        idle();
        t_start(); t_coarse(8'd3);
        for (int k = 0; k < 16; k++) t_fine(-7, 1'b0);
        check("R10 below", word_i(), -16);
        idle();

        // R6 abort mid-fine, then R5 clean restart
        t_start(); t_coarse(8'd50);
        for (int k = 0; k < 5; k++) t_fine(7, 1'b0);
        t_start();
        check("R6 err", int'(zoom_err), 1);
        check("R6 no vld", int'(zoom_vld), 0);
        t_coarse(8'd10);
        check("R6 err drop", int'(zoom_err), 0);
        for (int k = 0; k < 16; k++) t_fine(1, 1'b0);
        check("R5 word", word_i(), 336);
        idle();

        // R6 abort while waiting for coarse
        t_start();
        t_start();
        check("R6 coarse-wait err", int'(zoom_err), 1);
        t_coarse(8'd2);
        for (int k = 0; k < 16; k++) t_fine(0, 1'b0);
        check("R6 after restart", word_i(), 64);

        // R8 start coincides with 16th result
        t_start(); t_coarse(8'd4);
        for (int k = 0; k < 15; k++) t_fine(2, 1'b0);
        t_fine(2, 1'b1);
        check("R8 vld", int'(zoom_vld), 1);
        check("R8 err", int'(zoom_err), 0);
        check("R8 word", word_i(), 160);
        t_coarse(8'd6);
        for (int k = 0; k < 16; k++) t_fine(-1, 1'b0);
        check("R8 next word", word_i(), 176);
        idle();

        // R7 stray strobes ignored
        fin_vld = 1; fin_lvl = 4'sd7; @(negedge clk); fin_vld = 0;
        t_start();
        fin_vld = 1; fin_lvl = 4'sd7; @(negedge clk); fin_vld = 0;
        t_coarse(8'd9);
        for (int k = 0; k < 8; k++) t_fine(3, 1'b0);
        crs_vld = 1; crs_code = 8'd99; @(negedge clk); crs_vld = 0;
        for (int k = 0; k < 8; k++) t_fine(3, 1'b0);
        check("R7 word", word_i(), 288 + 48);
        idle();
        fin_vld = 1; fin_lvl = 4'sd5; @(negedge clk); fin_vld = 0;
        @(negedge clk);
        check("R7 no stray vld", int'(zoom_vld), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule